// File: doc/BRIEF.md
# Configurable Serial Character Receiver

This block recovers one asynchronous serial character from a single line that is sampled on the system clock. A character is a low start bit, eight data bits, one parity bit and one or two high stop bits. The bit period is a run-time count of system clocks. The line first passes through a synchronizer. The receiver then watches for a falling edge and checks the start bit again at its midpoint. This lets it reject glitches before it commits to a reception. After that it samples each later bit once, at the middle of its period.

Run-time inputs set the bit order, the parity sense and the number of stop bits. A finished character goes into a one-byte holding register. Three sticky flags report the result: data ready, overrun and frame error. A parity error and a bad stop bit both raise the same frame-error flag. An acknowledge pulse clears all three flags.

Two status outputs show how far reception has got. One rises as soon as a falling edge is seen, when the start may still be a glitch. The other rises only once the start is confirmed. A one-cycle end-of-frame strobe marks the last clock of the final stop bit.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the ready, overrun, frame-error, start-seen, busy and end-of-frame outputs are 0, and the held byte is 0.
- R2: A falling edge on an idle line raises `start_seen` 3 clocks after the line falls (2 synchronizer stages plus 1). `busy` stays low until the start bit has been sampled low at its midpoint, cnt = bit_clks/2. It rises 4 + bit_clks/2 clocks after the line falls, and `start_seen` drops at the same moment.
- R3: If the line is back high at the start-bit midpoint, the receiver returns to idle. `busy` never rises, no flag changes and no end-of-frame strobe is produced.
- R4: With `msb_first` = 0, line data bit i (0 = first after start) is byte bit i. With `msb_first` = 1, the first data bit is byte bit 7 and the last is bit 0.
- R5: With `odd_par` = 1, the eight data bits plus the parity bit must hold an odd number of ones. With `odd_par` = 0 the count must be even. A mismatch sets `frame_err`.
- R6: `two_stop` = 1 expects two stop bits and 0 expects one. Any stop bit sampled low sets `frame_err`.
- R7: A character with no errors, received while `ready` is clear, loads `rx_data` and sets `ready`.
- R8: A character with no errors that completes while `ready` is still set (and not acknowledged in that cycle) sets `overrun`, keeps `ready` set and loads `rx_data` with the new byte.
- R9: `eof` is high for exactly one clock, bits×bit_clks + 2 clocks after the line falls. Here bits = 11 with one stop bit and 12 with two. Flags update on the edge that ends this cycle.
- R10: An `ack` pulse clears `ready`, `overrun` and `frame_err` on the next clock edge. A completion in the same cycle still sets its flag.
- R11: When `busy` falls, at least one of `ready`, `overrun` or `frame_err` is set.
- R12: A character with a frame error leaves `rx_data` and `ready` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Asynchronous serial line, idle high |
| bit_clks_i | input | CPB_W (13) | System clocks per bit, at least 4 |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| odd_par_i | input | 1 | 1: odd parity, 0: even |
| msb_first_i | input | 1 | 1: data bit 7 first, 0: bit 0 first |
| ack_i | input | 1 | Clears ready, overrun and frame-error flags |
| rx_data_o | output | DATA_W (8) | Held received byte |
| ready_o | output | 1 | A new byte is held |
| overrun_o | output | 1 | A byte arrived before the previous one was acknowledged |
| frame_err_o | output | 1 | Parity or stop-bit error |
| start_seen_o | output | 1 | Falling edge seen, start not yet confirmed |
| busy_o | output | 1 | Confirmed reception in progress |
| eof_o | output | 1 | One-cycle strobe in the last clock of the last stop bit |

## Verification
Each result is due at a fixed cycle, counted from the edge at which the bench lowers the line. `start_seen` is due at 3 clocks, `busy` at 4 + bit_clks/2 clocks and the end-of-frame strobe at bits×bit_clks + 2 clocks. Flags and the held byte are valid one clock after the strobe, and an acknowledge clears the flags one clock after the pulse. The bench drives the line just after a rising edge and counts edges from there. It tests each timed output at its exact count and samples flags only after that count, so a design one clock early or late fails.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_PROBE = 3'd1,
      S_START = 3'd2,
      S_DATA  = 3'd3,
      S_PAR   = 3'd4,
      S_STOP1 = 3'd5,
      S_STOP2 = 3'd6
   } rx_state_t;

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s_o,
   output logic fall_o
);

   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign line_s_o = stage_q[STAGES-1];
   assign fall_o   = prev_q & ~stage_q[STAGES-1];

endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
   parameter int CPB_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic [CPB_W-1:0] bit_clks_i,
   output logic             mid_o,
   output logic             last_o
);

   logic [CPB_W-1:0] cnt_q;
   logic [CPB_W-1:0] half;
   logic [CPB_W-1:0] top;

   assign half   = bit_clks_i >> 1;
   assign top    = bit_clks_i - {{(CPB_W-1){1'b0}}, 1'b1};
   assign mid_o  = (cnt_q == half);
   assign last_o = (cnt_q == top);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (hold_i) cnt_q <= '0;
      else if (last_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + {{(CPB_W-1){1'b0}}, 1'b1};
   end

endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
   import serial_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_s_i,
   input  logic              fall_i,
   input  logic              mid_i,
   input  logic              last_i,
   input  logic              two_stop_i,
   input  logic              odd_par_i,
   input  logic              msb_first_i,
   output logic              idle_o,
   output logic              start_seen_o,
   output logic              busy_o,
   output logic              eof_o,
   output logic              bad_o,
   output logic [DATA_W-1:0] word_o
);

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   rx_state_t         state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] word_q;
   logic              err_q;
   logic              par_bad;

   assign par_bad      = ((^word_q) ^ line_s_i) != odd_par_i;
   assign idle_o       = (state_q == S_IDLE);
   assign start_seen_o = (state_q == S_PROBE);
   assign busy_o       = !(state_q == S_IDLE || state_q == S_PROBE);
   assign eof_o        = last_i && ((state_q == S_STOP1 && !two_stop_i) ||
                                    state_q == S_STOP2);
   assign bad_o        = err_q;
   assign word_o       = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         word_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (fall_i) begin
                  state_q <= S_PROBE;
                  err_q   <= 1'b0;
               end
            end
            S_PROBE: begin
               if (mid_i) state_q <= line_s_i ? S_IDLE : S_START;
            end
            S_START: begin
               if (last_i) begin
                  state_q <= S_DATA;
                  idx_q   <= '0;
               end
            end
            S_DATA: begin
               if (mid_i) begin
                  if (msb_first_i) word_q <= {word_q[DATA_W-2:0], line_s_i};
                  else             word_q <= {line_s_i, word_q[DATA_W-1:1]};
               end
               if (last_i) begin
                  if (idx_q == IDX_LAST) state_q <= S_PAR;
                  else                   idx_q   <= idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
               end
            end
            S_PAR: begin
               if (mid_i && par_bad) err_q <= 1'b1;
               if (last_i) state_q <= S_STOP1;
            end
            S_STOP1: begin
               if (mid_i && !line_s_i) err_q <= 1'b1;
               if (last_i) state_q <= two_stop_i ? S_STOP2 : S_IDLE;
            end
            S_STOP2: begin
               if (mid_i && !line_s_i) err_q <= 1'b1;
               if (last_i) state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/srx_status_reg.sv
module srx_status_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eof_i,
   input  logic              bad_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              ack_i,
   output logic [DATA_W-1:0] data_o,
   output logic              ready_o,
   output logic              overrun_o,
   output logic              frame_err_o
);

   logic still_held;

   assign still_held = ready_o & ~ack_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o      <= '0;
         ready_o     <= 1'b0;
         overrun_o   <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         if (ack_i) begin
            ready_o     <= 1'b0;
            overrun_o   <= 1'b0;
            frame_err_o <= 1'b0;
         end
         if (eof_i) begin
            if (bad_i) begin
               frame_err_o <= 1'b1;
            end else if (still_held) begin
               overrun_o <= 1'b1;
               data_o    <= word_i;
            end else begin
               ready_o <= 1'b1;
               data_o  <= word_i;
            end
         end
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter int CPB_W       = 13,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic [CPB_W-1:0]  bit_clks_i,
   input  logic              two_stop_i,
   input  logic              odd_par_i,
   input  logic              msb_first_i,
   input  logic              ack_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              ready_o,
   output logic              overrun_o,
   output logic              frame_err_o,
   output logic              start_seen_o,
   output logic              busy_o,
   output logic              eof_o
);

   if (CPB_W < 3) begin : g_bad_cpb
      $error("CPB_W must be at least 3");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic              line_s;
   logic              fall;
   logic              mid;
   logic              last;
   logic              idle;
   logic              bad;
   logic [DATA_W-1:0] word;

   srx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (line_i),
      .line_s_o (line_s),
      .fall_o   (fall)
   );

   srx_bit_timer #(.CPB_W(CPB_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_i     (idle),
      .bit_clks_i (bit_clks_i),
      .mid_o      (mid),
      .last_o     (last)
   );

   srx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_s_i     (line_s),
      .fall_i       (fall),
      .mid_i        (mid),
      .last_i       (last),
      .two_stop_i   (two_stop_i),
      .odd_par_i    (odd_par_i),
      .msb_first_i  (msb_first_i),
      .idle_o       (idle),
      .start_seen_o (start_seen_o),
      .busy_o       (busy_o),
      .eof_o        (eof_o),
      .bad_o        (bad),
      .word_o       (word)
   );

   srx_status_reg #(.DATA_W(DATA_W)) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .eof_i       (eof_o),
      .bad_i       (bad),
      .word_i      (word),
      .ack_i       (ack_i),
      .data_o      (rx_data_o),
      .ready_o     (ready_o),
      .overrun_o   (overrun_o),
      .frame_err_o (frame_err_o)
   );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              ready_o,
   input logic              overrun_o,
   input logic              frame_err_o,
   input logic              start_seen_o,
   input logic              busy_o,
   input logic              eof_o
);

   // R9
   eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |=> !eof_o);

   // R9
   eof_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |-> busy_o);

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !eof_o) |=> (!ready_o && !overrun_o && !frame_err_o));

   // R11
   result_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (ready_o || overrun_o || frame_err_o));

   // R2
   confirm_after_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_seen_o));

   // R8
   overrun_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o) |-> ready_o);

   // R12
   error_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_err_o) |-> $stable(rx_data_o));

endmodule

bind serial_rx_core srx_checker #(.DATA_W(DATA_W)) u_srx_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .ack_i        (ack_i),
   .rx_data_o    (rx_data_o),
   .ready_o      (ready_o),
   .overrun_o    (overrun_o),
   .frame_err_o  (frame_err_o),
   .start_seen_o (start_seen_o),
   .busy_o       (busy_o),
   .eof_o        (eof_o)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;

   typedef struct packed {
      logic [7:0] d;
      logic       msb;
      logic       odd;
      logic       two;
      logic       bpar;
      logic       bstop;
      logic       ack;
      logic       erdy;
      logic       eovr;
      logic       efe;
      logic [7:0] ed;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5},
      '{8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C},
      '{8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81},
      '{8'h7E, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h7E},
      '{8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h7E},
      '{8'h0F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h7E},
      '{8'hF0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hF0},
      '{8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line = 1'b1;
   logic [12:0] bit_clks = 13'd8;
   logic        two_stop = 1'b0;
   logic        odd_par = 1'b0;
   logic        msb_first = 1'b0;
   logic        ack = 1'b0;
   logic [7:0]  rx_data;
   logic        ready, overrun, frame_err, start_seen, busy, eof;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   serial_rx_core i_serial_rx_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_i       (line),
      .bit_clks_i   (bit_clks),
      .two_stop_i   (two_stop),
      .odd_par_i    (odd_par),
      .msb_first_i  (msb_first),
      .ack_i        (ack),
      .rx_data_o    (rx_data),
      .ready_o      (ready),
      .overrun_o    (overrun),
      .frame_err_o  (frame_err),
      .start_seen_o (start_seen),
      .busy_o       (busy),
      .eof_o        (eof)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_cycles(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   // Sends one frame; checks eof position (R9) and optionally start timing (R2).
   task automatic send_frame(input logic [7:0] d, input bit bpar, input bit bstop,
                             input bit chk_start);
      logic [11:0] bits;
      int nb;
      int half;
      int eof_cnt;
      int eof_at;
      logic par;
      nb   = two_stop ? 12 : 11;
      half = int'(bit_clks) / 2;
      par  = (^d) ^ odd_par ^ bpar;
      bits = '1;
      bits[0] = 1'b0;
      for (int i = 0; i < 8; i++) bits[1+i] = msb_first ? d[7-i] : d[i];
      bits[9] = par;
      if (bstop) bits[nb-1] = 1'b0;
      eof_cnt = 0;
      eof_at  = -1;
      for (int c = 0; c < nb * int'(bit_clks) + 6; c++) begin
         @(posedge clk);
         #1;
         line = (c < nb * int'(bit_clks)) ? bits[c / int'(bit_clks)] : 1'b1;
         #1;
         if (eof) begin
            eof_cnt++;
            eof_at = c;
         end
         if (chk_start && c == 3) begin
            check(start_seen == 1'b1, "R2 start_seen", start_seen, 1);
            check(busy == 1'b0, "R2 busy early", busy, 0);
         end
         if (chk_start && c == 3 + half)
            check(busy == 1'b0, "R2 busy before confirm", busy, 0);
         if (chk_start && c == 4 + half) begin
            check(busy == 1'b1, "R2 busy confirmed", busy, 1);
            check(start_seen == 1'b0, "R2 start_seen drop", start_seen, 0);
         end
      end
      check(eof_cnt == 1, "R9 eof count", eof_cnt, 1);
      check(eof_at == 2 + nb * int'(bit_clks), "R9 eof cycle", eof_at, 2 + nb * int'(bit_clks));
   endtask

   task automatic pulse_ack();
      @(posedge clk);
      #1 ack = 1'b1;
      @(posedge clk);
      #1 ack = 1'b0;
      #1;
      check({ready, overrun, frame_err} == 3'b000, "R10 ack clears",
            {ready, overrun, frame_err}, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      idle_cycles(3);
      // R1 reset state
      check({ready, overrun, frame_err, start_seen, busy, eof} == 6'b0, "R1 flags",
            {ready, overrun, frame_err, start_seen, busy, eof}, 0);
      check(rx_data == 8'h00, "R1 data", rx_data, 0);
      rst_n = 1'b1;
      idle_cycles(4);
      check({ready, overrun, frame_err, start_seen, busy} == 5'b0, "R1 idle line",
            {ready, overrun, frame_err, start_seen, busy}, 0);

      // R4 R5 R6 R7 R8 R12: table of frames
      for (int v = 0; v < NV; v++) begin
         msb_first = VEC[v].msb;
         odd_par   = VEC[v].odd;
         two_stop  = VEC[v].two;
         idle_cycles(2);
         send_frame(VEC[v].d, VEC[v].bpar, VEC[v].bstop, 1'b0);
         check(ready == VEC[v].erdy, "R7 ready", ready, VEC[v].erdy);
         check(overrun == VEC[v].eovr, "R8 overrun", overrun, VEC[v].eovr);
         check(frame_err == VEC[v].efe, "R5 R6 frame_err", frame_err, VEC[v].efe);
         check(rx_data == VEC[v].ed, "R4 R12 data", rx_data, VEC[v].ed);
         if (VEC[v].ack) pulse_ack();
      end

      // R3 glitch shorter than half a bit
      begin
         bit sb;
         bit by;
         bit ef;
         sb = 1'b0;
         by = 1'b0;
         ef = 1'b0;
         @(posedge clk);
         #1 line = 1'b0;
         repeat (2) @(posedge clk);
         #1 line = 1'b1;
         for (int c = 0; c < 3 * int'(bit_clks); c++) begin
            @(posedge clk);
            #2;
            if (start_seen) sb = 1'b1;
            if (busy) by = 1'b1;
            if (eof) ef = 1'b1;
         end
         check(sb == 1'b1, "R3 start_seen on glitch", sb, 1);
         check(by == 1'b0, "R3 busy on glitch", by, 0);
         check(ef == 1'b0, "R3 eof on glitch", ef, 0);
         check({ready, overrun, frame_err} == 3'b000, "R3 flags on glitch",
               {ready, overrun, frame_err}, 0);
         check(rx_data == 8'h00, "R3 data on glitch", rx_data, 0);
      end

      // R2 start timing with odd bit period, R4 MSB-first
      bit_clks  = 13'd13;
      msb_first = 1'b1;
      odd_par   = 1'b0;
      two_stop  = 1'b0;
      idle_cycles(2);
      send_frame(8'h01, 1'b0, 1'b0, 1'b1);
      check(ready == 1'b1, "R7 ready odd period", ready, 1);
      check(rx_data == 8'h01, "R4 msb_first odd period", rx_data, 8'h01);

      // R10 ack in the completing cycle: new flag still set, old cleared
      msb_first = 1'b0;
      idle_cycles(2);
      fork
         send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
         begin
            for (int c = 0; c < 12 * 13; c++) begin
               @(posedge clk);
               #3;
               if (eof) begin
                  ack = 1'b1;
                  @(posedge clk);
                  #1 ack = 1'b0;
                  break;
               end
            end
         end
      join
      check(ready == 1'b1, "R10 ack with completion keeps ready", ready, 1);
      check(overrun == 1'b0, "R10 ack with completion no overrun", overrun, 0);
      check(rx_data == 8'hC3, "R10 data with ack", rx_data, 8'hC3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule